// File: doc/BRIEF.md
# Indexed and Indirect Address Sequencer

This block produces the per-cycle bus activity of an 8-bit processor while it resolves a memory operand. It covers four addressing patterns: page-zero indexed reads, absolute indexed reads and writes, a two-byte pointer fetch through an indirect vector, and read-modify-write through an absolute indexed address. A one-cycle `start` strobe captures the mode, the operand bytes, the index, the address of the last instruction byte, the store data and a variant select. From the next cycle on, the block drives one bus access per cycle. It then raises `done` for one cycle and falls back to idle.

The variant select picks between two behaviours. The legacy behaviour reads the uncorrected wrong-page address during the page-carry penalty cycle, and writes the unmodified value back during the modify cycle. The revised behaviour re-reads the last instruction byte during the penalty cycle, and performs a harmless second read during the modify cycle. In both variants `valid` is low on every penalty, dummy or garbage cycle, so external logic can ignore those accesses.

Top module: `ixseq_top`

## Requirements
- R1: In page-zero indexed mode (`mode`=0), the first cycle is a dummy read of {0x00, base} with `valid` low. The second cycle reads {0x00, (base+index) mod 256} with `valid` high. The high byte is never carried into.
- R2: In vector mode (`mode`=3), the block reads {hi,lo} and then {hi,(lo+1) mod 256}. A pointer at offset 0xFF therefore takes its high byte from offset 0x00 of the same page. `target` becomes {second byte, first byte}.
- R3: An absolute indexed read (`mode`=1) whose low-byte sum carries takes two cycles. In the legacy variant (`revised`=0), the first cycle reads {hi, sum low byte} with `valid` low. The second cycle reads {hi+1, sum low byte} with `valid` high.
- R4: With `revised`=1, every penalty cycle of the absolute modes (1, 2, 4) reads `last_pc` instead of the uncorrected address.
- R5: An absolute indexed read without a carry performs exactly one read, with `valid` high, at the corrected address.
- R6: An absolute indexed write (`mode`=2) always takes the penalty cycle, even without a carry. It then writes `st_data` to the corrected address with `we`=1 and `valid` high.
- R7: Read-modify-write (`mode`=4) runs four cycles: penalty, then a read at the corrected address, then the modify cycle, then the final write. In the legacy variant the modify cycle writes the unmodified read value with `valid` low, and the final cycle writes the result with `valid` high.
- R8: In the revised variant the modify cycle is a read (`we`=0, `valid` low) of the corrected address. Only the final cycle writes.
- R9: `valid` is low on every penalty and dummy cycle and high on every real access.
- R10: `done` is high for exactly one cycle, the cycle after the last bus access. In that cycle `we` and `valid` are low, and `target` holds the effective address: the corrected address, the page-zero address, or the fetched vector. The next cycle is idle, with `addr`=0.
- R11: `rmw_op` selects the modify function: 0 adds one, 1 subtracts one (both wrapping modulo 256), 2 shifts left with a zero fill, 3 shifts right with a zero fill.
- R12: `start` is ignored while a sequence is in progress. The sequence already running is unchanged, and no new sequence follows it.
- R13: After reset, `addr`, `we`, `valid` and `done` are all zero.
- R14: Mode codes 5 to 7 perform no bus access. They raise `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (sampled only when idle) |
| mode | input | 3 | Addressing pattern code |
| rmw_op | input | 2 | Modify function for read-modify-write |
| revised | input | 1 | 0 = legacy behaviour, 1 = revised behaviour |
| op_lo | input | 8 | Operand low byte (base or pointer low) |
| op_hi | input | 8 | Operand high byte |
| index | input | 8 | Index register value |
| last_pc | input | 16 | Address of the last instruction byte |
| st_data | input | 8 | Data for indexed writes |
| rd_data | input | 8 | Read data from memory for the current address |
| addr | output | 16 | Bus address of the current cycle |
| we | output | 1 | Write strobe |
| wr_data | output | 8 | Write data |
| valid | output | 1 | High on real accesses, low on dummy cycles |
| done | output | 1 | One-cycle completion pulse |
| target | output | 16 | Effective address or fetched vector |

## Verification
The bench goes after the spots where the carry logic can slip. These are a page-zero sum above 0xFF, which a broken design would carry into page 1, and a pointer at offset 0xFF, which a broken design would finish on the next page. It also checks an absolute read that carries against one that does not; a broken design would either skip the penalty cycle or charge it every time. For each variant the bench compares the exact address of the penalty cycle and the `we` and `valid` of the modify cycle. A mix-up there would put a stray write on the bus, or a wrong-page read marked as valid. A `start` pulse in the middle of a sequence and the unused mode codes round this out: a faulty block would either restart or leave `done` low.

// File: rtl/ixseq_pkg.sv
package ixseq_pkg;
   localparam logic [2:0] MD_ZP_RD  = 3'd0;
   localparam logic [2:0] MD_ABS_RD = 3'd1;
   localparam logic [2:0] MD_ABS_WR = 3'd2;
   localparam logic [2:0] MD_VEC    = 3'd3;
   localparam logic [2:0] MD_RMW    = 3'd4;

   localparam logic [1:0] OP_INC = 2'd0;
   localparam logic [1:0] OP_DEC = 2'd1;
   localparam logic [1:0] OP_SHL = 2'd2;
   localparam logic [1:0] OP_SHR = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PEN,
      ST_ACC,
      ST_VHI,
      ST_MOD,
      ST_WB,
      ST_DONE
   } seq_st_e;
endpackage

// File: rtl/ixseq_agen.sv
module ixseq_agen #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] idx,
   output logic [ADDR_W-1:0] zp_addr,
   output logic [ADDR_W-1:0] uncorr_addr,
   output logic [ADDR_W-1:0] corr_addr,
   output logic [ADDR_W-1:0] vlo_addr,
   output logic [ADDR_W-1:0] vhi_addr
);
   localparam int PAGE_W = ADDR_W - DATA_W;

   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] lo_inc;
   logic [PAGE_W-1:0] hi_fix;

   assign sum    = {1'b0, lo} + {1'b0, idx};
   assign lo_inc = lo + {{(DATA_W-1){1'b0}}, 1'b1};
   assign hi_fix = hi + {{(PAGE_W-1){1'b0}}, sum[DATA_W]};

   assign zp_addr     = {{PAGE_W{1'b0}}, sum[DATA_W-1:0]};
   assign uncorr_addr = {hi, sum[DATA_W-1:0]};
   assign corr_addr   = {hi_fix, sum[DATA_W-1:0]};
   assign vlo_addr    = {hi, lo};
   assign vhi_addr    = {hi, lo_inc};
endmodule

// File: rtl/ixseq_modify.sv
module ixseq_modify #(
   parameter int DATA_W = 8
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   import ixseq_pkg::*;

   always_comb begin
      unique case (op)
         OP_INC:  dout = din + {{(DATA_W-1){1'b0}}, 1'b1};
         OP_DEC:  dout = din - {{(DATA_W-1){1'b0}}, 1'b1};
         OP_SHL:  dout = {din[DATA_W-2:0], 1'b0};
         default: dout = {1'b0, din[DATA_W-1:1]};
      endcase
   end
endmodule

// File: rtl/ixseq_fsm.sv
module ixseq_fsm #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [1:0]        rmw_op,
   input  logic              revised,
   input  logic [DATA_W-1:0] op_lo,
   input  logic [DATA_W-1:0] op_hi,
   input  logic [DATA_W-1:0] index,
   input  logic [ADDR_W-1:0] last_pc,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] zp_addr,
   input  logic [ADDR_W-1:0] uncorr_addr,
   input  logic [ADDR_W-1:0] corr_addr,
   input  logic [ADDR_W-1:0] vlo_addr,
   input  logic [ADDR_W-1:0] vhi_addr,
   input  logic [DATA_W-1:0] mod_result,
   output logic [DATA_W-1:0] lo_q,
   output logic [DATA_W-1:0] hi_q,
   output logic [DATA_W-1:0] idx_q,
   output logic [1:0]        mop_q,
   output logic [DATA_W-1:0] held_q,
   output logic [ADDR_W-1:0] addr,
   output logic              we,
   output logic [DATA_W-1:0] wr_data,
   output logic              valid,
   output logic              done,
   output logic [ADDR_W-1:0] target
);
   import ixseq_pkg::*;

   seq_st_e           st, st_nx;
   logic [2:0]        mode_q;
   logic              rev_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] sd_q, vlo_q, vhi_q;
   logic [DATA_W:0]   sum_now;
   logic              cross_now;
   logic [ADDR_W-1:0] pen_addr;

   assign sum_now   = {1'b0, op_lo} + {1'b0, index};
   assign cross_now = sum_now[DATA_W];
   assign pen_addr  = rev_q ? pc_q : uncorr_addr;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (start) begin
            case (mode)
               MD_ZP_RD:  st_nx = ST_PEN;
               MD_ABS_RD: st_nx = cross_now ? ST_PEN : ST_ACC;
               MD_ABS_WR: st_nx = ST_PEN;
               MD_VEC:    st_nx = ST_ACC;
               MD_RMW:    st_nx = ST_PEN;
               default:   st_nx = ST_DONE;
            endcase
         end
         ST_PEN:  st_nx = ST_ACC;
         ST_ACC:  st_nx = (mode_q == MD_VEC) ? ST_VHI :
                          (mode_q == MD_RMW) ? ST_MOD : ST_DONE;
         ST_VHI:  st_nx = ST_DONE;
         ST_MOD:  st_nx = ST_WB;
         ST_WB:   st_nx = ST_DONE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         mode_q <= '0;
         rev_q  <= 1'b0;
         pc_q   <= '0;
         sd_q   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         idx_q  <= '0;
         mop_q  <= '0;
         held_q <= '0;
         vlo_q  <= '0;
         vhi_q  <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_IDLE && start) begin
            mode_q <= mode;
            rev_q  <= revised;
            pc_q   <= last_pc;
            sd_q   <= st_data;
            lo_q   <= op_lo;
            hi_q   <= op_hi;
            idx_q  <= index;
            mop_q  <= rmw_op;
         end
         if (st == ST_ACC && mode_q == MD_VEC) vlo_q  <= rd_data;
         if (st == ST_ACC && mode_q == MD_RMW) held_q <= rd_data;
         if (st == ST_VHI)                     vhi_q  <= rd_data;
      end
   end

   always_comb begin
      addr    = '0;
      we      = 1'b0;
      wr_data = '0;
      valid   = 1'b0;
      done    = 1'b0;
      unique case (st)
         ST_PEN: addr = (mode_q == MD_ZP_RD) ? vlo_addr & {{(ADDR_W-DATA_W){1'b0}}, {DATA_W{1'b1}}}
                                             : pen_addr;
         ST_ACC: begin
            valid = 1'b1;
            if (mode_q == MD_ZP_RD)    addr = zp_addr;
            else if (mode_q == MD_VEC) addr = vlo_addr;
            else                       addr = corr_addr;
            if (mode_q == MD_ABS_WR) begin
               we      = 1'b1;
               wr_data = sd_q;
            end
         end
         ST_VHI: begin
            addr  = vhi_addr;
            valid = 1'b1;
         end
         ST_MOD: begin
            addr = corr_addr;
            if (!rev_q) begin
               we      = 1'b1;
               wr_data = held_q;
            end
         end
         ST_WB: begin
            addr    = corr_addr;
            we      = 1'b1;
            wr_data = mod_result;
            valid   = 1'b1;
         end
         ST_DONE: done = 1'b1;
         default: ;
      endcase
   end

   assign target = (mode_q == MD_VEC)   ? {vhi_q, vlo_q} :
                   (mode_q == MD_ZP_RD) ? zp_addr : corr_addr;

   // R10: completion strobe lasts one cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: no bus access during the completion cycle
   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!valid && !we));
   // R7: a garbage write is followed by the real write to the same address
   a_r7_garbage_then_real: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !valid) |=> (we && valid && $stable(addr)));
   // R8: revised variant never writes in the modify cycle
   a_r8_no_garbage_write: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MOD && rev_q) |-> !we);
   // R1: page-zero accesses stay in page zero
   a_r1_zp_page0: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACC && mode_q == MD_ZP_RD) |-> (addr[ADDR_W-1:DATA_W] == '0));
endmodule

// File: rtl/ixseq_top.sv
module ixseq_top #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [1:0]        rmw_op,
   input  logic              revised,
   input  logic [DATA_W-1:0] op_lo,
   input  logic [DATA_W-1:0] op_hi,
   input  logic [DATA_W-1:0] index,
   input  logic [ADDR_W-1:0] last_pc,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              we,
   output logic [DATA_W-1:0] wr_data,
   output logic              valid,
   output logic              done,
   output logic [ADDR_W-1:0] target
);
   localparam int PAGE_W = ADDR_W - DATA_W;

   generate
      if (PAGE_W != DATA_W) begin : g_bad_split
         $error("ixseq_top: ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("ixseq_top: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] lo_q, hi_q, idx_q, held_q, mod_result;
   logic [1:0]        mop_q;
   logic [ADDR_W-1:0] zp_addr, uncorr_addr, corr_addr, vlo_addr, vhi_addr;

   ixseq_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agen (
      .lo(lo_q), .hi(hi_q), .idx(idx_q),
      .zp_addr(zp_addr), .uncorr_addr(uncorr_addr), .corr_addr(corr_addr),
      .vlo_addr(vlo_addr), .vhi_addr(vhi_addr)
   );

   ixseq_modify #(.DATA_W(DATA_W)) u_mod (
      .op(mop_q), .din(held_q), .dout(mod_result)
   );

   ixseq_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rmw_op(rmw_op),
      .revised(revised), .op_lo(op_lo), .op_hi(op_hi), .index(index),
      .last_pc(last_pc), .st_data(st_data), .rd_data(rd_data),
      .zp_addr(zp_addr), .uncorr_addr(uncorr_addr), .corr_addr(corr_addr),
      .vlo_addr(vlo_addr), .vhi_addr(vhi_addr), .mod_result(mod_result),
      .lo_q(lo_q), .hi_q(hi_q), .idx_q(idx_q), .mop_q(mop_q), .held_q(held_q),
      .addr(addr), .we(we), .wr_data(wr_data), .valid(valid), .done(done),
      .target(target)
   );
endmodule

// File: tb/ixseq_top_test.sv
`timescale 1ns/1ps
module ixseq_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  rmw_op = '0;
   logic        revised = 1'b0;
   logic [7:0]  op_lo = '0, op_hi = '0, index = '0, st_data = '0;
   logic [15:0] last_pc = '0;
   logic [7:0]  rd_data;
   logic [15:0] addr, target;
   logic        we, valid, done;
   logic [7:0]  wr_data;
   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [15:0] a;
      logic        w;
      logic [7:0]  wd;
      logic        v;
      logic        d;
      logic [15:0] tg;
      logic        ctg;
      string       req;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   function automatic logic [7:0] mem_f(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   function automatic logic [7:0] modf(input logic [1:0] op, input logic [7:0] d);
      case (op)
         2'd0: return d + 8'd1;
         2'd1: return d - 8'd1;
         2'd2: return {d[6:0], 1'b0};
         default: return {1'b0, d[7:1]};
      endcase
   endfunction

   assign rd_data = mem_f(addr);

   ixseq_top uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rmw_op(rmw_op),
      .revised(revised), .op_lo(op_lo), .op_hi(op_hi), .index(index),
      .last_pc(last_pc), .st_data(st_data), .rd_data(rd_data),
      .addr(addr), .we(we), .wr_data(wr_data), .valid(valid), .done(done),
      .target(target)
   );

   task automatic push(input logic [15:0] a, input logic w, input logic [7:0] wd,
                       input logic v, input logic d, input logic [15:0] tg,
                       input logic ctg, input string req);
      exp_t e;
      e.a = a; e.w = w; e.wd = wd; e.v = v; e.d = d; e.tg = tg; e.ctg = ctg; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compares one expected item per cycle away from the clock edge
   always @(negedge clk) begin
      if (sb.size() != 0) begin
         exp_t e;
         logic bad;
         e = sb.pop_front();
         bad = (addr !== e.a) || (we !== e.w) || (valid !== e.v) || (done !== e.d) ||
               (e.w && wr_data !== e.wd) || (e.ctg && target !== e.tg);
         checks++;
         if (bad) begin
            errors++;
            $display("FAIL %s: got addr=%h we=%b wd=%h v=%b d=%b tg=%h exp addr=%h we=%b wd=%h v=%b d=%b tg=%h",
                     e.req, addr, we, wr_data, valid, done, target,
                     e.a, e.w, e.wd, e.v, e.d, e.tg);
         end
      end
   end

   task automatic run(input logic [2:0] md, input logic [1:0] op, input logic rev,
                      input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] ix,
                      input logic [15:0] pc, input logic [7:0] sd, input logic glitch);
      logic [8:0]  sum;
      logic [15:0] unc, cor, zp, pen, vlo, vhi;
      logic [7:0]  d;
      sum = {1'b0, lo} + {1'b0, ix};
      unc = {hi, sum[7:0]};
      cor = {hi + {7'b0, sum[8]}, sum[7:0]};
      zp  = {8'h00, sum[7:0]};
      pen = rev ? pc : unc;
      vlo = {hi, lo};
      vhi = {hi, lo + 8'd1};
      d   = mem_f(cor);
      @(negedge clk);
      mode = md; rmw_op = op; revised = rev; op_lo = lo; op_hi = hi;
      index = ix; last_pc = pc; st_data = sd; start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      case (md)
         3'd0: begin
            push({8'h00, lo}, 0, 0, 0, 0, 0, 0, "R9");
            push(zp, 0, 0, 1, 0, 0, 0, "R1");
            push(0, 0, 0, 0, 1, zp, 1, "R1");
         end
         3'd1: begin
            if (sum[8]) push(pen, 0, 0, 0, 0, 0, 0, rev ? "R4" : "R3");
            push(cor, 0, 0, 1, 0, 0, 0, sum[8] ? "R3" : "R5");
            push(0, 0, 0, 0, 1, cor, 1, "R10");
         end
         3'd2: begin
            push(pen, 0, 0, 0, 0, 0, 0, rev ? "R4" : "R6");
            push(cor, 1, sd, 1, 0, 0, 0, "R6");
            push(0, 0, 0, 0, 1, cor, 1, "R10");
         end
         3'd3: begin
            push(vlo, 0, 0, 1, 0, 0, 0, "R2");
            push(vhi, 0, 0, 1, 0, 0, 0, "R2");
            push(0, 0, 0, 0, 1, {mem_f(vhi), mem_f(vlo)}, 1, "R2");
         end
         3'd4: begin
            push(pen, 0, 0, 0, 0, 0, 0, rev ? "R4" : "R9");
            push(cor, 0, 0, 1, 0, 0, 0, "R7");
            if (rev) push(cor, 0, 0, 0, 0, 0, 0, "R8");
            else     push(cor, 1, d, 0, 0, 0, 0, "R7");
            push(cor, 1, modf(op, d), 1, 0, 0, 0, "R11");
            push(0, 0, 0, 0, 1, cor, 1, "R10");
         end
         default: push(0, 0, 0, 0, 1, 0, 0, "R14");
      endcase
      push(0, 0, 0, 0, 0, 0, 0, glitch ? "R12" : "R10");
      if (glitch) begin
         @(negedge clk);
         mode = 3'd3; op_lo = 8'h77; start = 1'b1;
         @(posedge clk);
         #1 start = 1'b0;
      end
      do @(posedge clk); while (sb.size() != 0);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (addr !== 16'h0 || we !== 1'b0 || valid !== 1'b0 || done !== 1'b0) begin
         errors++;
         $display("FAIL R13: got addr=%h we=%b v=%b d=%b exp all zero", addr, we, valid, done);
      end
      rst_n = 1'b1;
      // R1: page-zero wrap
      run(3'd0, 0, 0, 8'hF0, 8'h44, 8'h20, 16'h8001, 8'h00, 0);
      run(3'd0, 0, 1, 8'h10, 8'h00, 8'h05, 16'h8001, 8'h00, 0);
      // R5 / R3 / R4: absolute indexed read
      run(3'd1, 0, 0, 8'h30, 8'h12, 8'h05, 16'h8003, 8'h00, 0);
      run(3'd1, 0, 0, 8'hF0, 8'h12, 8'h20, 16'h8003, 8'h00, 0);
      run(3'd1, 0, 1, 8'hF0, 8'h12, 8'h20, 16'h8003, 8'h00, 0);
      run(3'd1, 0, 0, 8'hFF, 8'hFF, 8'h01, 16'h8003, 8'h00, 0);
      // R6: absolute indexed write, with and without a carry
      run(3'd2, 0, 0, 8'h30, 8'h12, 8'h05, 16'h9002, 8'hA5, 0);
      run(3'd2, 0, 1, 8'hE0, 8'h20, 8'h40, 16'h9002, 8'h5A, 0);
      // R2: vector fetch, page-end pointer and ordinary pointer
      run(3'd3, 0, 0, 8'hFF, 8'h30, 8'h00, 16'h0000, 8'h00, 0);
      run(3'd3, 0, 1, 8'h10, 8'h30, 8'h00, 16'h0000, 8'h00, 0);
      // R7 / R8 / R11: read-modify-write in both variants, all modify functions
      run(3'd4, 2'd0, 0, 8'hF0, 8'h12, 8'h20, 16'hA002, 8'h00, 0);
      run(3'd4, 2'd1, 1, 8'hF0, 8'h12, 8'h20, 16'hA002, 8'h00, 0);
      run(3'd4, 2'd2, 0, 8'h40, 8'h05, 8'h01, 16'hA002, 8'h00, 0);
      run(3'd4, 2'd3, 1, 8'h40, 8'h05, 8'h01, 16'hA002, 8'h00, 0);
      // R12: start during a sequence is ignored
      run(3'd4, 2'd0, 1, 8'h22, 8'h33, 8'h11, 16'hB002, 8'h00, 1);
      // R14: unused mode codes
      run(3'd5, 0, 0, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 0);
      run(3'd7, 0, 1, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 0);
      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule